// File: doc/BRIEF.md
# Per-Channel Threshold Alarm Monitor

This block watches a stream of conversion results, each tagged with the channel it came from. Every channel has its own programmable high limit, low limit and hysteresis. A result above the high limit raises that channel's high alarm. A result below the low limit raises its low alarm. Once raised, an alarm falls only when a later result for that channel has moved back past the limit by more than the hysteresis. This keeps a noisy signal near a limit from toggling the alarm.

Each channel has two flags. The active flag shows the present alarm state. The tripped flag records that an alarm was present on some sample, and it stays set until the host pulses the read strobe. A single active-high alarm output is raised whenever any tripped flag is set. Results with the valid strobe low, or with a tag that names no existing channel, leave all state untouched. Register decoding sits outside the block. Thresholds and hysteresis arrive as flat packed vectors, with channel i in slice i.

Top module: `alarm_mon`

## Requirements
- R1: After reset, all active flags, all tripped flags and alarm_o are 0.
- R2: A valid result for channel c that is strictly greater than c's high threshold sets c's high alarm, visible in active_o one clock later. A result equal to the threshold does not set it.
- R3: A raised high alarm stays set while results are at or above (high threshold - hysteresis). It clears only when result + hysteresis < high threshold. The sum is computed without wrap, so a hysteresis larger than the threshold never clears the alarm.
- R4: A valid result strictly below c's low threshold sets c's low alarm. A result equal to the threshold does not set it.
- R5: A raised low alarm clears only when the result is greater than (low threshold + hysteresis). The sum is computed without wrap, so it never clears when that sum exceeds the largest result value.
- R6: active_o[c] is the OR of c's high and low alarms. tripped_o[c] sets on the clock after any valid result for c that leaves c's active state at 1, and then stays set until a read.
- R7: A flag_rd_i pulse clears every tripped flag on the next clock. A result in the same cycle that leaves its channel active sets that flag anyway. A condition still present after a read sets the flag again on its next result.
- R8: alarm_o is 1 exactly when at least one tripped flag is 1. It is registered and aligned with tripped_o.
- R9: Results with res_valid_i = 0, or with a res_ch_i tag value of NUM_CH or more, change no flag.
- R10: Bit i of active_o and tripped_o belongs to channel i. Channel i's thresholds occupy bits [i*16 +: 16] of the threshold and hysteresis inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| res_valid_i | input | 1 | Result strobe |
| res_ch_i | input | 4 | Channel tag of the result |
| res_data_i | input | 16 | Conversion result (unsigned) |
| hi_thr_i | input | 128 | Packed high thresholds, 16 bits per channel |
| lo_thr_i | input | 128 | Packed low thresholds, 16 bits per channel |
| hyst_i | input | 128 | Packed hysteresis values, 16 bits per channel |
| flag_rd_i | input | 1 | Clear strobe for all tripped flags |
| active_o | output | 8 | Present alarm state per channel |
| tripped_o | output | 8 | Latched alarm per channel |
| alarm_o | output | 1 | OR of all tripped flags |

## Verification
The hardest situations to reach from the ports are the hysteresis band edges and their behaviour under arithmetic extremes. Examples are a result exactly at threshold minus hysteresis, a hysteresis larger than the high limit, and a low limit plus hysteresis beyond full scale. A read strobe landing in the same cycle as an alarm-setting result is equally hard to reach. Directed sequences place results on each boundary value and its neighbours, and they collide a read with a setting sample. Seeded random stimulus then concentrates results within a few thousand counts of each channel's limits. It mixes in invalid tags and random reads, so that alarms enter and leave the band many times.

// File: rtl/alarm_mon_pkg.sv
package alarm_mon_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } alm_state_t;

  localparam alm_state_t ALM_IDLE = '{hi: 1'b0, lo: 1'b0};
endpackage

// File: rtl/alarm_sel.sv
module alarm_sel #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned TAG_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic [NUM_CH-1:0] sel_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign sel_o[i] = valid_i && (tag_i == TAG_W'(i));
  end

  // R9: at most one channel takes a result per cycle
  a_r9_onehot_sel: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(sel_o));
  a_r9_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |-> sel_o == '0);
endmodule

// File: rtl/alarm_chan.sv
module alarm_chan
  import alarm_mon_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned HYST_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] hi_thr_i,
  input  logic [DATA_W-1:0] lo_thr_i,
  input  logic [HYST_W-1:0] hyst_i,
  output alm_state_t        state_o,
  output logic              act_nxt_o
);
  localparam int unsigned XW = DATA_W + 1;

  alm_state_t state_q, state_d;
  logic [XW-1:0] data_x, hi_x, lo_x, hyst_x;
  logic hi_set, hi_clr, lo_set, lo_clr;

  // one extra bit so threshold +/- hysteresis never wraps
  assign data_x = {1'b0, data_i};
  assign hi_x   = {1'b0, hi_thr_i};
  assign lo_x   = {1'b0, lo_thr_i};
  assign hyst_x = XW'(hyst_i);

  assign hi_set = data_x > hi_x;
  assign hi_clr = (data_x + hyst_x) < hi_x;
  assign lo_set = data_x < lo_x;
  assign lo_clr = data_x > (lo_x + hyst_x);

  always_comb begin
    state_d = state_q;
    if (smp_i) begin
      state_d.hi = hi_set | (state_q.hi & ~hi_clr);
      state_d.lo = lo_set | (state_q.lo & ~lo_clr);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ALM_IDLE;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign act_nxt_o = state_d.hi | state_d.lo;

  a_r2_high_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_i && (data_i > hi_thr_i) |=> state_q.hi);
  a_r4_low_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_i && (data_i < lo_thr_i) |=> state_q.lo);
  a_r3_high_band_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_i && state_q.hi && (int'(data_i) + int'(hyst_i) >= int'(hi_thr_i)) |=> state_q.hi);
  a_r5_low_band_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_i && state_q.lo && (int'(data_i) <= int'(lo_thr_i) + int'(hyst_i)) |=> state_q.lo);
  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_i |=> $stable(state_q));
endmodule

// File: rtl/alarm_trip.sv
module alarm_trip #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_i,
  input  logic              rd_i,
  output logic [NUM_CH-1:0] tripped_o,
  output logic              alarm_o
);
  logic [NUM_CH-1:0] trip_q, trip_d;
  logic              alarm_q;

  // set wins over a read in the same cycle
  assign trip_d = (rd_i ? '0 : trip_q) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_q  <= '0;
      alarm_q <= 1'b0;
    end else begin
      trip_q  <= trip_d;
      alarm_q <= |trip_d;
    end
  end

  assign tripped_o = trip_q;
  assign alarm_o   = alarm_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_i && trip_q[i] |=> trip_q[i]);
    a_r7_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_i && !set_i[i] |=> !trip_q[i]);
    a_r6_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> trip_q[i]);
  end

  a_r8_alarm_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_q == (trip_q != '0));
endmodule

// File: rtl/alarm_mon.sv
module alarm_mon
  import alarm_mon_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned HYST_W = 16,
  parameter int unsigned TAG_W  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     res_valid_i,
  input  logic [TAG_W-1:0]         res_ch_i,
  input  logic [DATA_W-1:0]        res_data_i,
  input  logic [NUM_CH*DATA_W-1:0] hi_thr_i,
  input  logic [NUM_CH*DATA_W-1:0] lo_thr_i,
  input  logic [NUM_CH*HYST_W-1:0] hyst_i,
  input  logic                     flag_rd_i,
  output logic [NUM_CH-1:0]        active_o,
  output logic [NUM_CH-1:0]        tripped_o,
  output logic                     alarm_o
);
  logic [NUM_CH-1:0] sel, trip_set;
  alm_state_t        st [NUM_CH];
  logic [NUM_CH-1:0] act_nxt;

  alarm_sel #(.NUM_CH(NUM_CH), .TAG_W(TAG_W)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (res_valid_i),
    .tag_i   (res_ch_i),
    .sel_o   (sel)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    alarm_chan #(.DATA_W(DATA_W), .HYST_W(HYST_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .smp_i     (sel[i]),
      .data_i    (res_data_i),
      .hi_thr_i  (hi_thr_i[i*DATA_W +: DATA_W]),
      .lo_thr_i  (lo_thr_i[i*DATA_W +: DATA_W]),
      .hyst_i    (hyst_i[i*HYST_W +: HYST_W]),
      .state_o   (st[i]),
      .act_nxt_o (act_nxt[i])
    );
    assign active_o[i] = st[i].hi | st[i].lo;
    assign trip_set[i] = sel[i] & act_nxt[i];
  end

  alarm_trip #(.NUM_CH(NUM_CH)) u_trip (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (trip_set),
    .rd_i      (flag_rd_i),
    .tripped_o (tripped_o),
    .alarm_o   (alarm_o)
  );

  a_r9_bad_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_valid_i || res_ch_i >= TAG_W'(NUM_CH)) && !flag_rd_i |=> $stable(active_o) && $stable(tripped_o));
  a_r6_active_trips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && res_ch_i < TAG_W'(NUM_CH) && res_data_i > hi_thr_i[res_ch_i*DATA_W +: DATA_W]
    |=> tripped_o != '0);
endmodule

// File: tb/tb_alarm_mon.sv
module tb_alarm_mon;
  localparam int NCH = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic vld = 1'b0, rd = 1'b0;
  logic [3:0] ch = '0;
  logic [15:0] dat = '0;
  logic [NCH*16-1:0] hi_thr = '0, lo_thr = '0, hyst = '0;
  logic [NCH-1:0] act_o, trip_o;
  logic alm_o;
  int checks = 0, errors = 0;
  bit mh [NCH], ml [NCH], mt [NCH];
  int rhi [NCH], rlo [NCH], rhy [NCH];

  always #5 clk = ~clk;

  alarm_mon dut (
    .clk_i(clk), .rst_ni(rst_n), .res_valid_i(vld), .res_ch_i(ch), .res_data_i(dat),
    .hi_thr_i(hi_thr), .lo_thr_i(lo_thr), .hyst_i(hyst), .flag_rd_i(rd),
    .active_o(act_o), .tripped_o(trip_o), .alarm_o(alm_o)
  );

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic int exp_act();
    int v = 0;
    for (int c = 0; c < NCH; c++) if (mh[c] || ml[c]) v |= (1 << c);
    return v;
  endfunction
  function automatic int exp_trip();
    int v = 0;
    for (int c = 0; c < NCH; c++) if (mt[c]) v |= (1 << c);
    return v;
  endfunction

  task automatic cfg(int c, int h, int l, int y);
    rhi[c] = h; rlo[c] = l; rhy[c] = y;
    hi_thr[c*16 +: 16] = 16'(h);
    lo_thr[c*16 +: 16] = 16'(l);
    hyst[c*16 +: 16]   = 16'(y);
  endtask

  // model from requirements R2..R7, R9
  function automatic void model(bit v, int c, int d, bit r);
    if (r) for (int k = 0; k < NCH; k++) mt[k] = 0;
    if (v && c < NCH) begin
      if (d > rhi[c]) mh[c] = 1;
      else if (mh[c] && d + rhy[c] < rhi[c]) mh[c] = 0;
      if (d < rlo[c]) ml[c] = 1;
      else if (ml[c] && d > rlo[c] + rhy[c]) ml[c] = 0;
      if (mh[c] || ml[c]) mt[c] = 1;
    end
  endfunction

  task automatic cyc(bit v, int c, int d, bit r, string req);
    vld = v; ch = 4'(c); dat = 16'(d); rd = r;
    model(v, c, d, r);
    @(posedge clk); #2;
    chk({req, " active"}, int'(act_o), exp_act());
    chk({req, " tripped"}, int'(trip_o), exp_trip());
    chk({req, " alarm R8"}, int'(alm_o), (exp_trip() != 0) ? 1 : 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7411));
    for (int c = 0; c < NCH; c++) begin cfg(c, 60000, 100, 0); mh[c] = 0; ml[c] = 0; mt[c] = 0; end
    #23 rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 active", int'(act_o), 0);
    chk("R1 tripped", int'(trip_o), 0);
    chk("R1 alarm", int'(alm_o), 0);

    // R2/R3 boundaries on channel 3
    cfg(3, 1000, 100, 50);
    cyc(1, 3, 1000, 0, "R2 equal no set");
    cyc(1, 3, 1001, 0, "R2 set R10");
    cyc(1, 3, 950, 0, "R3 band hold");
    cyc(1, 3, 949, 0, "R3 clear");
    cyc(0, 3, 5000, 0, "R9 valid low");
    cyc(1, 9, 65535, 0, "R9 bad tag");
    cyc(1, 3, 500, 1, "R7 read clear");
    // R3 no-wrap: hysteresis above threshold
    cfg(5, 10, 0, 100);
    cyc(1, 5, 11, 0, "R3 set ch5 R10");
    cyc(1, 5, 0, 0, "R3 no wrap hold");
    // R4/R5 on channel 1, no-wrap overflow
    cfg(1, 65535, 65520, 256);
    cyc(1, 1, 65520, 0, "R4 equal no set");
    cyc(1, 1, 65519, 0, "R4 set");
    cyc(1, 1, 65535, 0, "R5 no wrap hold");
    cfg(2, 65535, 2000, 100);
    cyc(1, 2, 1999, 0, "R4 set ch2");
    cyc(1, 2, 2100, 0, "R5 band hold");
    cyc(1, 2, 2101, 0, "R5 clear");
    // R7 collision and re-arm
    cyc(1, 1, 65535, 1, "R7 read with set");
    cyc(0, 0, 0, 1, "R7 read");
    cyc(1, 5, 3, 0, "R7 re-arm R6");
    cyc(0, 0, 0, 0, "R6 sticky");

    // random
    for (int c = 0; c < NCH; c++) cfg(c, 20000 + $urandom % 40000, $urandom % 20000, $urandom % 2000);
    for (int n = 0; n < 3000; n++) begin
      int c, d, sel;
      c = $urandom % 10;
      sel = $urandom % 3;
      if (c < NCH && sel == 0) d = rhi[c] - 3000 + $urandom % 6000;
      else if (c < NCH && sel == 1) d = rlo[c] - 3000 + $urandom % 6000;
      else d = $urandom % 65536;
      if (d < 0) d = 0;
      if (d > 65535) d = 65535;
      if (n % 500 == 499) for (int k = 0; k < NCH; k++) cfg(k, 20000 + $urandom % 40000, $urandom % 20000, $urandom % 2000);
      cyc(($urandom % 5) != 0, c, d, ($urandom % 10) == 0, "R2 R3 R4 R5 R6 R7 R9 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule